// File: doc/BRIEF.md
# Indexed Block Control-Register Slave for a Two-Wire Bus

This block sits on a two-wire SMBus/I2C segment as a target device and holds a small file of eight control bytes. A host sets a starting index and then either writes a counted run of bytes or, after a repeated start, reads a run back. Each access begins at the chosen index, and the index advances by one after every byte, wrapping from the last register to the first. A read answers first with a byte count and then with register contents. The host decides how many bytes it takes by acknowledging each one and refusing the last.

The register file drives the rest of the chip through one flat parallel bus. Most bits can be written. The reserved bits always read back their fixed values. The three strap readback bits are latched from input pins just after reset and are read-only. The identification byte is read-only and is built from a revision input and a fixed vendor code. The bus lines pass through synchronizers into the core clock domain. The block drives the data line only by pulling it low, and it does so only while the bus clock is low.

Top module: `ctl_reg_smb_slave`

## Requirements
- R1: Only address byte 0xD2 (write) and 0xD3 (read), i.e. 7-bit address 0x69, is acknowledged. Any other address byte is left unacknowledged, and every following byte is ignored and left unacknowledged until the next start condition.
- R2: A write transaction is start, 0xD2, index N, count X, then X data bytes. Every one of these bytes is acknowledged, and data byte k is stored at register (N+k) mod 8.
- R3: A read transaction is start, 0xD2, index N, repeated start, 0xD3. The slave then sends the count value 8, followed by registers N, N+1, ... for as long as the host acknowledges.
- R4: After reset the registers hold: byte0 0xFF, byte1 0xFE, byte2 0xFF, byte3 0x00, byte4 0x00, byte5 0x00, byte6 0x08 OR strap, byte7 {rev_id_i, 4'b0001}.
- R5: Byte 6 bits 2:0 equal strap_fs_i as sampled in the first clock after reset release. Later strap changes and bus writes to these bits have no effect.
- R6: Byte 7 is read-only. Bits 7:4 are rev_id_i and bits 3:0 are the constant 0001. Writes to it change nothing.
- R7: Only these bits are writable: byte0 mask 0xFE, byte1 0xF7, byte2 0xFF, byte3 0xFE, byte4 0x70, byte5 0x8F, byte6 0xD8. All other bits keep their reset value on writes.
- R8: The index byte is taken modulo 8 (index 11 addresses register 3). The running index wraps from 7 to 0 on both writes and reads.
- R9: Data bytes beyond the written count are not acknowledged and not stored. With count 0, the first data byte is already refused.
- R10: A stop or start condition inside a byte ends the transaction without storing the partial byte. A start re-arms address reception at once.
- R11: The SDA pull-down changes only while the synchronized SCL is low.
- R12: ctl_image_o carries register i on bits 8i+7:8i and reflects a completed write within a few core clocks of the byte's acknowledge.
- R13: During a read, a host not-acknowledge ends the transfer and the slave releases SDA. After that it stays quiet until the next start condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; must be several times faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_drive_low_o | output | 1 | When high, the pad pulls SDA low (open drain) |
| strap_fs_i | input | 3 | Strap levels latched into byte 6 bits 2:0 after reset |
| rev_id_i | input | 4 | Revision code shown in byte 7 bits 7:4 |
| ctl_image_o | output | 64 | Read image of all eight registers, register i at bits 8i+7:8i |

## Verification
The hardest situations to create from the ports are the mid-byte aborts. In these, a stop or a repeated start arrives after only a few data bits of a write whose index and count were already accepted. The bench bit-bangs the bus one half-cycle at a time. It can therefore break off a byte after any number of bits and then confirm on the parallel image that nothing moved and that a following complete transaction still lands. Counted overruns, address mismatches and index wrap on both reads and writes are driven through the same host tasks. Every byte a read returns goes into a queue and is compared against a register model kept in the bench.

// File: rtl/ctl_smb_pkg.sv
package ctl_smb_pkg;

  localparam logic [3:0] VENDOR_CODE = 4'b0001;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_INDEX,
    ST_COUNT,
    ST_WDATA,
    ST_ACK_WAIT,
    ST_ACK_HOLD,
    ST_TX,
    ST_TX_ACK,
    ST_TX_NEXT
  } link_state_e;

  // Bits a host write may change.
  function automatic logic [7:0] reg_wmask(int unsigned idx);
    case (idx)
      0:       return 8'hFE;
      1:       return 8'hF7;
      2:       return 8'hFF;
      3:       return 8'hFE;
      4:       return 8'h70;
      5:       return 8'h8F;
      6:       return 8'hD8;
      default: return 8'h00;
    endcase
  endfunction

  // Reset value of the stored and reserved bits.
  function automatic logic [7:0] reg_default(int unsigned idx);
    case (idx)
      0:       return 8'hFF;
      1:       return 8'hFE;
      2:       return 8'hFF;
      6:       return 8'h08;
      default: return 8'h00;
    endcase
  endfunction

  // Bits sourced from inputs rather than storage.
  function automatic logic [7:0] reg_romask(int unsigned idx);
    case (idx)
      6:       return 8'h07;
      7:       return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/smb_pin_sync.sv
module smb_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s_o,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_det_o,
  output logic stop_det_o
);

  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic              scl_q;
  logic              sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s_o     = scl_ff[STAGES-1];
  assign sda_s_o     = sda_ff[STAGES-1];
  assign scl_rise_o  = scl_s_o & ~scl_q;
  assign scl_fall_o  = ~scl_s_o & scl_q;
  assign start_det_o = scl_s_o & scl_q & sda_q & ~sda_s_o;
  assign stop_det_o  = scl_s_o & scl_q & ~sda_q & sda_s_o;

endmodule

// File: rtl/smb_link_ctrl.sv
module smb_link_ctrl
  import ctl_smb_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h69,
  parameter logic [7:0] READ_COUNT = 8'd8,
  parameter int         IW         = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_s_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_det_i,
  input  logic          stop_det_i,
  input  logic [7:0]    rd_byte_i,
  output logic [IW-1:0] rd_idx_o,
  output logic          wr_en_o,
  output logic [IW-1:0] wr_idx_o,
  output logic [7:0]    wr_data_o,
  output logic          sda_low_o
);

  link_state_e   state_q, state_n;
  link_state_e   after_q, after_n;
  logic [6:0]    shreg_q, shreg_n;
  logic [2:0]    bit_cnt_q, bit_cnt_n;
  logic [IW-1:0] ptr_q, ptr_n;
  logic [7:0]    remain_q, remain_n;
  logic [7:0]    tx_sh_q, tx_sh_n;
  logic          wr_en_q, wr_en_n;
  logic [IW-1:0] wr_idx_q, wr_idx_n;
  logic [7:0]    wr_data_q, wr_data_n;
  logic [7:0]    byte_v;

  always_comb begin
    state_n   = state_q;
    after_n   = after_q;
    shreg_n   = shreg_q;
    bit_cnt_n = bit_cnt_q;
    ptr_n     = ptr_q;
    remain_n  = remain_q;
    tx_sh_n   = tx_sh_q;
    wr_en_n   = 1'b0;
    wr_idx_n  = wr_idx_q;
    wr_data_n = wr_data_q;
    byte_v    = {shreg_q, sda_s_i};
    if (stop_det_i) begin
      state_n = ST_IDLE;
    end else if (start_det_i) begin
      state_n   = ST_ADDR;
      bit_cnt_n = 3'd0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_INDEX, ST_COUNT, ST_WDATA: begin
          if (scl_rise_i) begin
            shreg_n   = byte_v[6:0];
            bit_cnt_n = bit_cnt_q + 3'd1;
            if (bit_cnt_q == 3'd7) begin
              state_n = ST_ACK_WAIT;
              case (state_q)
                ST_ADDR: begin
                  if (byte_v[7:1] != SLAVE_ADDR) begin
                    state_n = ST_IDLE;
                  end else if (byte_v[0]) begin
                    after_n = ST_TX;
                    tx_sh_n = READ_COUNT;
                  end else begin
                    after_n = ST_INDEX;
                  end
                end
                ST_INDEX: begin
                  ptr_n   = byte_v[IW-1:0];
                  after_n = ST_COUNT;
                end
                ST_COUNT: begin
                  remain_n = byte_v;
                  after_n  = ST_WDATA;
                end
                default: begin
                  if (remain_q == 8'd0) begin
                    state_n = ST_IDLE;
                  end else begin
                    wr_en_n   = 1'b1;
                    wr_idx_n  = ptr_q;
                    wr_data_n = byte_v;
                    ptr_n     = ptr_q + 1'b1;
                    remain_n  = remain_q - 8'd1;
                    after_n   = ST_WDATA;
                  end
                end
              endcase
            end
          end
        end
        ST_ACK_WAIT: begin
          if (scl_fall_i) state_n = ST_ACK_HOLD;
        end
        ST_ACK_HOLD: begin
          if (scl_fall_i) begin
            state_n   = after_q;
            bit_cnt_n = 3'd0;
          end
        end
        ST_TX: begin
          if (scl_fall_i) begin
            if (bit_cnt_q == 3'd7) begin
              state_n   = ST_TX_ACK;
              bit_cnt_n = 3'd0;
            end else begin
              tx_sh_n   = {tx_sh_q[6:0], 1'b0};
              bit_cnt_n = bit_cnt_q + 3'd1;
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise_i) begin
            if (!sda_s_i) begin
              state_n = ST_TX_NEXT;
              tx_sh_n = rd_byte_i;
              ptr_n   = ptr_q + 1'b1;
            end else begin
              state_n = ST_IDLE;
            end
          end
        end
        ST_TX_NEXT: begin
          if (scl_fall_i) begin
            state_n   = ST_TX;
            bit_cnt_n = 3'd0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      after_q   <= ST_IDLE;
      shreg_q   <= '0;
      bit_cnt_q <= '0;
      ptr_q     <= '0;
      remain_q  <= '0;
      tx_sh_q   <= '0;
      wr_en_q   <= 1'b0;
      wr_idx_q  <= '0;
      wr_data_q <= '0;
    end else begin
      state_q   <= state_n;
      after_q   <= after_n;
      shreg_q   <= shreg_n;
      bit_cnt_q <= bit_cnt_n;
      ptr_q     <= ptr_n;
      remain_q  <= remain_n;
      tx_sh_q   <= tx_sh_n;
      wr_en_q   <= wr_en_n;
      wr_idx_q  <= wr_idx_n;
      wr_data_q <= wr_data_n;
    end
  end

  assign rd_idx_o  = ptr_q;
  assign wr_en_o   = wr_en_q;
  assign wr_idx_o  = wr_idx_q;
  assign wr_data_o = wr_data_q;
  assign sda_low_o = (state_q == ST_ACK_HOLD) | ((state_q == ST_TX) & ~tx_sh_q[7]);

  a_r10_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det_i |=> (state_q == ST_IDLE));

  a_r10_start_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det_i && !stop_det_i) |=> (state_q == ST_ADDR && bit_cnt_q == 3'd0));

  a_r8_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_q |-> (ptr_q == IW'(wr_idx_q + 1'b1)));

  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_n |-> (remain_q != 8'd0));

endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank
  import ctl_smb_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int IW       = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en_i,
  input  logic [IW-1:0]         wr_idx_i,
  input  logic [7:0]            wr_data_i,
  input  logic [2:0]            strap_i,
  input  logic [3:0]            rev_i,
  input  logic [IW-1:0]         rd_idx_i,
  output logic [7:0]            rd_byte_o,
  output logic [NUM_REGS*8-1:0] image_o
);

  logic [2:0] strap_q;
  logic       strap_taken_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_q       <= 3'b000;
      strap_taken_q <= 1'b0;
    end else if (!strap_taken_q) begin
      strap_q       <= strap_i;
      strap_taken_q <= 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [7:0] WM = reg_wmask(g);
    localparam logic [7:0] DF = reg_default(g);
    localparam logic [7:0] RO = reg_romask(g);
    logic [7:0] cell_q;
    logic [7:0] cell_n;
    logic [7:0] ro_val;
    logic       hit;

    always_comb begin
      hit    = wr_en_i && (wr_idx_i == IW'(g));
      cell_n = (cell_q & ~WM) | (wr_data_i & WM);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cell_q <= DF & WM;
      end else if (hit) begin
        cell_q <= cell_n;
      end
    end

    if (g == 6) begin : g_strap
      assign ro_val = {5'b00000, strap_q};
    end else if (g == 7) begin : g_ident
      assign ro_val = {rev_i, VENDOR_CODE};
    end else begin : g_plain
      assign ro_val = 8'h00;
    end

    assign image_o[8*g +: 8] = (cell_q & WM) | (DF & ~WM & ~RO) | (ro_val & RO);
  end

  assign rd_byte_o = image_o[{rd_idx_i, 3'b000} +: 8];

  a_r5_strap_wr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_idx_i == IW'(6)) |=> (image_o[50:48] == $past(image_o[50:48])));

  a_r6_ident_wr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_idx_i == IW'(7)) |=> (image_o[59:56] == $past(image_o[59:56])));

endmodule

// File: rtl/ctl_reg_smb_slave.sv
module ctl_reg_smb_slave
  import ctl_smb_pkg::*;
#(
  parameter int         NUM_REGS    = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] SLAVE_ADDR  = 7'h69,
  parameter logic [7:0] READ_COUNT  = 8'd8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_drive_low_o,
  input  logic [2:0]            strap_fs_i,
  input  logic [3:0]            rev_id_i,
  output logic [NUM_REGS*8-1:0] ctl_image_o
);

  localparam int IW = $clog2(NUM_REGS);

  logic [1:0]    rst_ff;
  logic          rst_core_n;
  logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [7:0]    rd_byte;
  logic [IW-1:0] rd_idx;
  logic          wr_en;
  logic [IW-1:0] wr_idx;
  logic [7:0]    wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= 2'b00;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_core_n = rst_ff[1];

  smb_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .scl_i       (scl_i),
    .sda_i       (sda_i),
    .scl_s_o     (scl_s),
    .sda_s_o     (sda_s),
    .scl_rise_o  (scl_rise),
    .scl_fall_o  (scl_fall),
    .start_det_o (start_det),
    .stop_det_o  (stop_det)
  );

  smb_link_ctrl #(
    .SLAVE_ADDR (SLAVE_ADDR),
    .READ_COUNT (READ_COUNT),
    .IW         (IW)
  ) u_link (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .sda_s_i     (sda_s),
    .scl_rise_i  (scl_rise),
    .scl_fall_i  (scl_fall),
    .start_det_i (start_det),
    .stop_det_i  (stop_det),
    .rd_byte_i   (rd_byte),
    .rd_idx_o    (rd_idx),
    .wr_en_o     (wr_en),
    .wr_idx_o    (wr_idx),
    .wr_data_o   (wr_data),
    .sda_low_o   (sda_drive_low_o)
  );

  ctl_reg_bank #(.NUM_REGS(NUM_REGS), .IW(IW)) u_bank (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_data),
    .strap_i   (strap_fs_i),
    .rev_i     (rev_id_i),
    .rd_idx_i  (rd_idx),
    .rd_byte_o (rd_byte),
    .image_o   (ctl_image_o)
  );

  a_r11_sda_scl_low: assert property (@(posedge clk) disable iff (!rst_core_n)
    !$stable(sda_drive_low_o) |-> !scl_s);

endmodule

// File: tb/ctl_reg_smb_slave_bench.sv
module ctl_reg_smb_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl = 1'b1;
  logic        host_sda = 1'b1;
  logic [2:0]  strap = 3'b101;
  logic [3:0]  rev = 4'hA;
  logic        dut_low;
  logic        sda_line;
  logic [63:0] ctl;

  assign sda_line = host_sda & ~dut_low;

  ctl_reg_smb_slave u_ctl_reg_smb_slave (
    .clk             (clk),
    .rst_n           (rst_n),
    .scl_i           (scl),
    .sda_i           (sda_line),
    .sda_drive_low_o (dut_low),
    .strap_fs_i      (strap),
    .rev_id_i        (rev),
    .ctl_image_o     (ctl)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [7:0] val;
    string      tag;
  } exp_t;

  int         checks = 0;
  int         errors = 0;
  int         drive_viol = 0;
  bit         done = 1'b0;
  logic [7:0] model [8];
  logic [7:0] wbuf [16];
  exp_t       exp_q [$];
  logic [7:0] obs_q [$];

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  function automatic logic [7:0] wmask(int i);
    case (i)
      0: return 8'hFE;
      1: return 8'hF7;
      2: return 8'hFF;
      3: return 8'hFE;
      4: return 8'h70;
      5: return 8'h8F;
      6: return 8'hD8;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [63:0] model_img();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[8*i +: 8] = model[i];
    return v;
  endfunction

  task automatic q_wait(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wbit(bit b);
    q_wait(Q); host_sda = b; q_wait(Q); scl = 1'b1; q_wait(2*Q); scl = 1'b0;
  endtask

  task automatic rbit(output bit b);
    q_wait(Q); host_sda = 1'b1; q_wait(Q); scl = 1'b1; q_wait(Q);
    b = sda_line; q_wait(Q); scl = 1'b0;
  endtask

  task automatic bus_start();
    q_wait(Q); host_sda = 1'b1; q_wait(Q); scl = 1'b1; q_wait(Q);
    host_sda = 1'b0; q_wait(Q); scl = 1'b0;
  endtask

  task automatic bus_stop();
    q_wait(Q); host_sda = 1'b0; q_wait(Q); scl = 1'b1; q_wait(Q);
    host_sda = 1'b1; q_wait(2*Q);
  endtask

  task automatic send_bits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) wbit(b[i]);
  endtask

  task automatic send_byte(logic [7:0] b, output bit ack);
    bit a;
    send_bits(b, 8);
    rbit(a);
    ack = !a;
  endtask

  task automatic recv_byte(bit give_ack);
    bit         a;
    logic [7:0] b;
    for (int i = 7; i >= 0; i--) begin
      rbit(a);
      b[i] = a;
    end
    wbit(!give_ack);
    obs_q.push_back(b);
  endtask

  task automatic send_expect(logic [7:0] b, bit want_ack, string tag);
    bit ack;
    send_byte(b, ack);
    check(ack == want_ack, tag, ack, want_ack);
  endtask

  task automatic reg_write(logic [7:0] idx, logic [7:0] cnt, int nbytes, string tag);
    bus_start();
    send_expect(8'hD2, 1'b1, {tag, " addr"});
    send_expect(idx, 1'b1, {tag, " index"});
    send_expect(cnt, 1'b1, {tag, " count"});
    for (int k = 0; k < nbytes; k++) begin
      send_expect(wbuf[k], k < cnt, {tag, " data ack"});
      if (k < cnt) begin
        int r;
        r = (idx + k) % 8;
        model[r] = (model[r] & ~wmask(r)) | (wbuf[k] & wmask(r));
      end
    end
    bus_stop();
    q_wait(4);
    check(ctl === model_img(), {tag, " R12 image"}, ctl, model_img());
  endtask

  task automatic reg_read(logic [7:0] idx, int n, string tag);
    exp_t e;
    e.val = 8'd8; e.tag = {tag, " count"};
    exp_q.push_back(e);
    for (int k = 0; k < n; k++) begin
      e.val = model[(idx + k) % 8];
      e.tag = {tag, " data"};
      exp_q.push_back(e);
    end
    bus_start();
    send_expect(8'hD2, 1'b1, {tag, " addr"});
    send_expect(idx, 1'b1, {tag, " index"});
    bus_start();
    send_expect(8'hD3, 1'b1, {tag, " read addr"});
    recv_byte(1'b1);
    for (int k = 0; k < n; k++) recv_byte(k < n - 1);
    q_wait(2*Q);
    check(sda_line === 1'b1, {tag, " R13 released"}, sda_line, 1'b1);
    bus_stop();
  endtask

  // Scoreboard monitor.
  initial begin
    exp_t       e;
    logic [7:0] got;
    forever begin
      wait (obs_q.size() > 0);
      got = obs_q.pop_front();
      if (exp_q.size() == 0) begin
        check(1'b0, "R3 unexpected byte", got, 0);
      end else begin
        e = exp_q.pop_front();
        check(got === e.val, e.tag, got, e.val);
      end
    end
  end

  // R11: pull-down must not move while the bus clock is high.
  logic scl_prev = 1'b1;
  logic low_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && scl && scl_prev && (dut_low !== low_prev)) drive_viol++;
    scl_prev <= scl;
    low_prev <= dut_low;
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 0);
    finish_run();
  end

  initial begin
    model[0] = 8'hFF; model[1] = 8'hFE; model[2] = 8'hFF; model[3] = 8'h00;
    model[4] = 8'h00; model[5] = 8'h00; model[6] = 8'h08 | {5'b0, strap};
    model[7] = {rev, 4'b0001};
    q_wait(5);
    rst_n = 1'b1;
    q_wait(10);

    check(ctl === model_img(), "R4 reset image", ctl, model_img());
    check(dut_low === 1'b0, "R11 idle release", dut_low, 0);

    // R2/R7: write three bytes from index 2.
    wbuf[0] = 8'h5A; wbuf[1] = 8'hFF; wbuf[2] = 8'hFF;
    reg_write(8'd2, 8'd3, 3, "R2 write");
    check(ctl[31:24] === 8'hFE && ctl[39:32] === 8'h70, "R7 reserved bits",
          ctl[39:24], 16'h70FE);

    // R3: full read from index 0.
    reg_read(8'd0, 8, "R3 read");

    // R1: foreign address ignored until next start.
    bus_start();
    send_expect(8'hA0, 1'b0, "R1 foreign addr");
    send_expect(8'h01, 1'b0, "R1 ignored index");
    send_expect(8'h00, 1'b0, "R1 ignored data");
    bus_stop();
    check(ctl === model_img(), "R1 no change", ctl, model_img());

    // R5/R6/R8: write across bytes 6, 7 and wrap to 0.
    wbuf[0] = 8'hFF; wbuf[1] = 8'h00; wbuf[2] = 8'h32;
    reg_write(8'd6, 8'd3, 3, "R5 R6 R8 write wrap");
    check(ctl[63:56] === 8'hA1, "R6 ident", ctl[63:56], 8'hA1);
    check(ctl[55:48] === 8'hDD, "R5 strap bits kept", ctl[55:48], 8'hDD);
    check(ctl[7:0] === 8'h33, "R8 wrap to 0", ctl[7:0], 8'h33);
    strap = 3'b010;
    q_wait(20);
    check(ctl[50:48] === 3'b101, "R5 late strap ignored", ctl[50:48], 3'b101);

    // R8: index above range, then read that wraps.
    wbuf[0] = 8'h81;
    reg_write(8'd11, 8'd1, 1, "R8 index modulo");
    check(ctl[31:24] === 8'h80, "R8 index 11 hits 3", ctl[31:24], 8'h80);
    reg_read(8'd6, 4, "R8 read wrap");

    // R9: overrun and zero count.
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    reg_write(8'd5, 8'd1, 2, "R9 overrun");
    wbuf[0] = 8'h00;
    reg_write(8'd2, 8'd0, 1, "R9 zero count");

    // R10: stop in mid byte.
    bus_start();
    send_expect(8'hD2, 1'b1, "R10 addr");
    send_expect(8'h01, 1'b1, "R10 index");
    send_expect(8'h01, 1'b1, "R10 count");
    send_bits(8'h00, 4);
    bus_stop();
    q_wait(4);
    check(ctl === model_img(), "R10 stop abort", ctl, model_img());

    // R10: repeated start in mid byte, then a clean write lands.
    bus_start();
    send_expect(8'hD2, 1'b1, "R10 addr b");
    send_expect(8'h04, 1'b1, "R10 index b");
    send_expect(8'h01, 1'b1, "R10 count b");
    send_bits(8'h00, 3);
    q_wait(4);
    check(ctl === model_img(), "R10 start abort", ctl, model_img());
    wbuf[0] = 8'h0F;
    reg_write(8'd5, 8'd1, 1, "R10 after restart");

    // R13: short read, host refuses after two bytes.
    reg_read(8'd1, 2, "R13 short read");
    bus_start();
    send_expect(8'hD3, 1'b1, "R13 quiet then new start");
    exp_q.push_back('{val: 8'd8, tag: "R13 count again"});
    recv_byte(1'b0);
    bus_stop();

    wait (obs_q.size() == 0);
    q_wait(10);
    check(exp_q.size() == 0, "R3 all bytes seen", exp_q.size(), 0);
    check(drive_viol == 0, "R11 drive only while SCL low", drive_viol, 0);
    finish_run();
  end

endmodule